// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Scanner

This block keeps, for each CPU, a record of the most urgent interrupt that is waiting to be delivered. The record holds the interrupt's ID, its priority and its group. The scanner examines one interrupt ID per clock. For each ID it reads that ID's eligibility, priority, group and routing from the surrounding register state, through a combinational lookup port.

Two kinds of request start a scan. A range update re-examines only a window of shared IDs whose state has just changed. A full recompute clears every record and then walks all shared IDs followed by each CPU's private IDs 0 to 31. A range update can remove the old winner, for example when that interrupt stops being eligible. If the old winner lies inside the window and the window offers nothing equal or better, the scanner runs a full recompute on its own before it reports completion.

Requests use a valid/ready handshake. The block signals `busy_o` while a scan runs and gives a one-cycle `done_o` when the records are final.

Top module: `hppi_scanner`

## Requirements
- R1: After reset every CPU's record holds the "none" priority 0xFF, `busy_o` and `done_o` are low and `req_ready_o` is high.
- R2: A candidate replaces a CPU's record when its priority value is numerically lower. At equal priority it also replaces the record when its ID is lower than or equal to the recorded ID, so an equal-priority candidate with a higher ID never displaces the recorded one.
- R3: A full recompute first sets every record's priority to 0xFF. It then scans shared IDs 32 to NUM_IRQ-1, routing each one to its target CPU, and then scans private IDs 0 to 31 of CPU 0, CPU 1 and so on. A private ID therefore wins a priority tie against a shared ID.
- R4: An eligible shared ID whose target is not valid is skipped and changes no record.
- R5: A range update examines only shared IDs from `req_start_i` to `req_start_i+req_len_i-1`. A CPU whose recorded ID lies outside that window keeps its record unless the window holds a better candidate for it.
- R6: If, after a range update, a CPU has a valid record (not 0xFF) whose ID is inside the window, and no candidate in the window was accepted for that CPU, the scanner performs a full recompute before it signals completion.
- R7: Whenever a candidate is accepted, the CPU's group field takes `grp_i` for that candidate's ID.
- R8: `done_o` is high for exactly one cycle. After the accepting clock edge it comes (NUM_IRQ-32)+32*NUM_CPU edges later for a full recompute, and len+1 edges later for a range update with no fallback. When R6 applies, the full-recompute count is added to len+1.
- R9: `req_ready_o` is high only while idle. A request presented while busy is held and is accepted only after the current scan completes, with no effect on the running scan.
- R10: Eligibility comes from 32-bit words whose bit i belongs to ID (word_base+i). The word is fetched at the first ID of a scan and at every ID whose low five bits are zero, so a window that starts in the middle of a word uses the correct bits.
- R11: While idle and with no request accepted, every record stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Scanner can accept a request |
| req_full_i | input | 1 | 1: full recompute, 0: range update |
| req_start_i | input | ID_W | First shared ID of the window (at least 32) |
| req_len_i | input | ID_W+1 | Number of IDs in the window (at least 1) |
| scan_id_o | output | ID_W | ID currently examined |
| scan_cpu_o | output | CPU_W | CPU whose private ID is examined |
| scan_priv_o | output | 1 | 1 while private IDs are scanned |
| elig_word_i | input | 32 | Eligibility word for the 32-aligned block holding `scan_id_o` |
| prio_i | input | PRIO_W | Priority of the examined ID |
| grp_i | input | GRP_W | Group of the examined ID |
| tgt_cpu_i | input | CPU_W | Target CPU of the examined shared ID |
| tgt_valid_i | input | 1 | Target CPU is valid |
| best_prio_o | output | NUM_CPU*PRIO_W | Recorded priority per CPU (CPU c in slice c) |
| best_id_o | output | NUM_CPU*ID_W | Recorded ID per CPU |
| best_grp_o | output | NUM_CPU*GRP_W | Recorded group per CPU |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check on every cycle that `done_o` is a single-cycle pulse and that a scan starts only after a presented request. They also check that a record's priority never gets worse during a scan step, that an untargeted shared ID leaves every record untouched, and that records hold still while idle. The bench scenarios are needed to show that the final records are right. These cover tie-breaking between shared and private IDs, windows that start mid-word, the fallback to a full rescan and its extra latency, re-acceptance of an equal candidate, and a request held back while the scanner is busy.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SHARED,
        PH_PRIV,
        PH_CHECK,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/hppi_cmp.sv
module hppi_cmp #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 7
) (
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] best_prio_i,
    input  logic [ID_W-1:0]   best_id_i,
    output logic              take_o
);
    // lower value is more urgent; ties go to the lower or equal ID
    always_comb begin
        take_o = (cand_prio_i < best_prio_i) ||
                 ((cand_prio_i == best_prio_i) && (cand_id_i <= best_id_i));
    end
endmodule

// File: rtl/hppi_fallback.sv
module hppi_fallback #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 7
) (
    input  logic              seen_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [ID_W-1:0]   lo_i,
    input  logic [ID_W-1:0]   hi_i,
    output logic              need_o
);
    // old winner sat in the window and nothing re-claimed it
    always_comb begin
        need_o = !seen_i && (prio_i != '1) && (id_i >= lo_i) && (id_i <= hi_i);
    end
endmodule

// File: rtl/hppi_scanner.sv
module hppi_scanner
    import hppi_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 96,
    parameter int PRIO_W  = 8,
    parameter int GRP_W   = 2,
    localparam int ID_W   = $clog2(NUM_IRQ),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      req_valid_i,
    output logic                      req_ready_o,
    input  logic                      req_full_i,
    input  logic [ID_W-1:0]           req_start_i,
    input  logic [ID_W:0]             req_len_i,
    output logic [ID_W-1:0]           scan_id_o,
    output logic [CPU_W-1:0]          scan_cpu_o,
    output logic                      scan_priv_o,
    input  logic [WORD_W-1:0]         elig_word_i,
    input  logic [PRIO_W-1:0]         prio_i,
    input  logic [GRP_W-1:0]          grp_i,
    input  logic [CPU_W-1:0]          tgt_cpu_i,
    input  logic                      tgt_valid_i,
    output logic [NUM_CPU*PRIO_W-1:0] best_prio_o,
    output logic [NUM_CPU*ID_W-1:0]   best_id_o,
    output logic [NUM_CPU*GRP_W-1:0]  best_grp_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int PRIV_N = 32;

    typedef struct packed {
        phase_e                          phase;
        logic                            full;
        logic                            first;
        logic [ID_W-1:0]                 id;
        logic [ID_W-1:0]                 rstart;
        logic [ID_W-1:0]                 rend;
        logic [CPU_W-1:0]                cpu;
        logic [WORD_W-1:0]               word;
        logic [NUM_CPU-1:0]              seen;
        logic [NUM_CPU-1:0][PRIO_W-1:0]  prio;
        logic [NUM_CPU-1:0][ID_W-1:0]    bid;
        logic [NUM_CPU-1:0][GRP_W-1:0]   grp;
    } st_t;

    st_t st_q, st_d;

    logic [WORD_W-1:0] cur_word;
    logic              cand_elig;
    logic              in_priv;
    logic [CPU_W-1:0]  cand_cpu;
    logic              cand_ok;
    logic              better;
    logic              take;
    logic [NUM_CPU-1:0] need_full;
    logic [ID_W:0]     end_calc;

    function automatic st_t begin_full(st_t s);
        st_t r;
        r        = s;
        r.phase  = PH_SHARED;
        r.full   = 1'b1;
        r.first  = 1'b1;
        r.id     = ID_W'(PRIV_N);
        r.rstart = ID_W'(PRIV_N);
        r.rend   = ID_W'(NUM_IRQ-1);
        r.seen   = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            r.prio[c] = '1;
        end
        return r;
    endfunction

    // word fetched at scan start and at each 32-aligned boundary
    always_comb begin
        cur_word  = (st_q.first || (st_q.id[4:0] == 5'd0)) ? elig_word_i : st_q.word;
        cand_elig = cur_word[st_q.id[4:0]];
        in_priv   = (st_q.phase == PH_PRIV);
        cand_cpu  = in_priv ? st_q.cpu : tgt_cpu_i;
        cand_ok   = cand_elig && (in_priv || tgt_valid_i) && (int'(cand_cpu) < NUM_CPU);
        take      = cand_ok && better &&
                    ((st_q.phase == PH_SHARED) || (st_q.phase == PH_PRIV));
        end_calc  = {1'b0, req_start_i} + req_len_i - 1'b1;
    end

    hppi_cmp #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_cmp (
        .cand_prio_i (prio_i),
        .cand_id_i   (st_q.id),
        .best_prio_i (st_q.prio[cand_cpu]),
        .best_id_i   (st_q.bid[cand_cpu]),
        .take_o      (better)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_fb
        hppi_fallback #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_fb (
            .seen_i (st_q.seen[g]),
            .prio_i (st_q.prio[g]),
            .id_i   (st_q.bid[g]),
            .lo_i   (st_q.rstart),
            .hi_i   (st_q.rend),
            .need_o (need_full[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.prio[cand_cpu] = prio_i;
            st_d.bid[cand_cpu]  = st_q.id;
            st_d.grp[cand_cpu]  = grp_i;
            st_d.seen[cand_cpu] = 1'b1;
        end
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    if (req_full_i) begin
                        st_d = begin_full(st_q);
                    end else begin
                        st_d.phase  = PH_SHARED;
                        st_d.full   = 1'b0;
                        st_d.first  = 1'b1;
                        st_d.id     = req_start_i;
                        st_d.rstart = req_start_i;
                        st_d.rend   = end_calc[ID_W-1:0];
                        st_d.seen   = '0;
                    end
                end
            end
            PH_SHARED: begin
                st_d.word  = cur_word;
                st_d.first = 1'b0;
                if (st_q.id == st_q.rend) begin
                    if (st_q.full) begin
                        st_d.phase = PH_PRIV;
                        st_d.cpu   = '0;
                        st_d.id    = '0;
                        st_d.first = 1'b1;
                    end else begin
                        st_d.phase = PH_CHECK;
                    end
                end else begin
                    st_d.id = st_q.id + ID_W'(1);
                end
            end
            PH_PRIV: begin
                st_d.word  = cur_word;
                st_d.first = 1'b0;
                if (st_q.id == ID_W'(PRIV_N-1)) begin
                    st_d.id = '0;
                    if (st_q.cpu == CPU_W'(NUM_CPU-1)) begin
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.cpu   = st_q.cpu + CPU_W'(1);
                        st_d.first = 1'b1;
                    end
                end else begin
                    st_d.id = st_q.id + ID_W'(1);
                end
            end
            PH_CHECK: begin
                if (|need_full) begin
                    st_d = begin_full(st_q);
                end else begin
                    st_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            for (int c = 0; c < NUM_CPU; c++) begin
                st_q.prio[c] <= '1;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o = (st_q.phase == PH_IDLE);
    assign busy_o      = (st_q.phase != PH_IDLE);
    assign done_o      = (st_q.phase == PH_DONE);
    assign scan_id_o   = st_q.id;
    assign scan_cpu_o  = st_q.cpu;
    assign scan_priv_o = in_priv;
    assign best_prio_o = st_q.prio;
    assign best_id_o   = st_q.bid;
    assign best_grp_o  = st_q.grp;

    // completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // a scan begins only after a request was presented
    assert_start_on_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(req_valid_i));

    // an untargeted shared ID changes no record
    assert_skip_untargeted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_SHARED && !tgt_valid_i) |=>
            ($stable(best_prio_o) && $stable(best_id_o) && $stable(best_grp_o)));

    // records hold while idle and nothing is accepted
    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !req_valid_i) |=>
            ($stable(best_prio_o) && $stable(best_id_o) && $stable(best_grp_o)));

    // a scan step never makes a record less urgent
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_mono
        assert_no_worse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.phase == PH_SHARED || st_q.phase == PH_PRIV) |=>
                (best_prio_o[g*PRIO_W +: PRIO_W] <= $past(best_prio_o[g*PRIO_W +: PRIO_W])));
    end
endmodule

// File: tb/hppi_scanner_bench.sv
module hppi_scanner_bench;
    localparam int C    = 2;
    localparam int N    = 96;
    localparam int PW   = 8;
    localparam int GW   = 2;
    localparam int IW   = $clog2(N);
    localparam int CW   = 1;
    localparam int FULL_LAT = (N - 32) + 32 * C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid, req_ready, req_full;
    logic [IW-1:0]     req_start;
    logic [IW:0]       req_len;
    logic [IW-1:0]     scan_id;
    logic [CW-1:0]     scan_cpu;
    logic              scan_priv;
    logic [31:0]       elig_word;
    logic [PW-1:0]     prio_in;
    logic [GW-1:0]     grp_in;
    logic [CW-1:0]     tgt_cpu;
    logic              tgt_valid;
    logic [C*PW-1:0]   best_prio;
    logic [C*IW-1:0]   best_id;
    logic [C*GW-1:0]   best_grp;
    logic              busy, done;

    hppi_scanner #(.NUM_CPU(C), .NUM_IRQ(N), .PRIO_W(PW), .GRP_W(GW)) u_hppi_scanner (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_full_i(req_full),
        .req_start_i(req_start), .req_len_i(req_len),
        .scan_id_o(scan_id), .scan_cpu_o(scan_cpu), .scan_priv_o(scan_priv),
        .elig_word_i(elig_word), .prio_i(prio_in), .grp_i(grp_in),
        .tgt_cpu_i(tgt_cpu), .tgt_valid_i(tgt_valid),
        .best_prio_o(best_prio), .best_id_o(best_id), .best_grp_o(best_grp),
        .busy_o(busy), .done_o(done)
    );

    // environment register state
    logic        s_elig [N];
    logic [7:0]  s_prio [N];
    logic [1:0]  s_grp  [N];
    logic        s_tgt  [N];
    logic        s_tgtv [N];
    logic        p_elig [C][32];
    logic [7:0]  p_prio [C][32];
    logic [1:0]  p_grp  [C][32];

    always_comb begin
        elig_word = '0;
        for (int b = 0; b < 32; b++) begin
            if (scan_priv) elig_word[b] = p_elig[scan_cpu][b];
            else if ({scan_id[IW-1:5], 5'd0} + b < N)
                elig_word[b] = s_elig[int'({scan_id[IW-1:5], 5'd0}) + b];
        end
        if (scan_priv) begin
            prio_in   = p_prio[scan_cpu][scan_id[4:0]];
            grp_in    = p_grp[scan_cpu][scan_id[4:0]];
            tgt_cpu   = '0;
            tgt_valid = 1'b0;
        end else begin
            prio_in   = s_prio[scan_id];
            grp_in    = s_grp[scan_id];
            tgt_cpu   = s_tgt[scan_id];
            tgt_valid = s_tgtv[scan_id];
        end
    end

    // reference records
    int m_prio [C];
    int m_id   [C];
    int m_grp  [C];

    typedef struct {
        int prio [C];
        int id   [C];
        int grp  [C];
        int lat;
        string tag;
    } exp_t;
    exp_t exp_q [$];
    int   acc_q [$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit m_better(int c, int p, int id);
        return (p < m_prio[c]) || (p == m_prio[c] && id <= m_id[c]);
    endfunction

    task automatic m_full();
        for (int c = 0; c < C; c++) m_prio[c] = 255;
        for (int i = 32; i < N; i++) begin
            if (s_elig[i] && s_tgtv[i] && m_better(int'(s_tgt[i]), s_prio[i], i)) begin
                m_prio[s_tgt[i]] = s_prio[i]; m_id[s_tgt[i]] = i; m_grp[s_tgt[i]] = s_grp[i];
            end
        end
        for (int c = 0; c < C; c++)
            for (int i = 0; i < 32; i++)
                if (p_elig[c][i] && m_better(c, p_prio[c][i], i)) begin
                    m_prio[c] = p_prio[c][i]; m_id[c] = i; m_grp[c] = p_grp[c][i];
                end
    endtask

    task automatic m_range(input int st, input int len, output bit fb);
        bit seen [C];
        for (int c = 0; c < C; c++) seen[c] = 1'b0;
        for (int i = st; i < st + len; i++) begin
            if (s_elig[i] && s_tgtv[i] && m_better(int'(s_tgt[i]), s_prio[i], i)) begin
                m_prio[s_tgt[i]] = s_prio[i]; m_id[s_tgt[i]] = i; m_grp[s_tgt[i]] = s_grp[i];
                seen[s_tgt[i]] = 1'b1;
            end
        end
        fb = 1'b0;
        for (int c = 0; c < C; c++)
            if (!seen[c] && m_prio[c] != 255 && m_id[c] >= st && m_id[c] < st + len) fb = 1'b1;
        if (fb) m_full();
    endtask

    // driver: compute expectation, push it, then hand the request over
    task automatic send(input bit full, input int st, input int len, input string tag);
        exp_t e;
        bit fb;
        if (full) begin
            m_full();
            e.lat = FULL_LAT;
        end else begin
            m_range(st, len, fb);
            e.lat = len + 1 + (fb ? FULL_LAT : 0);
        end
        for (int c = 0; c < C; c++) begin
            e.prio[c] = m_prio[c]; e.id[c] = m_id[c]; e.grp[c] = m_grp[c];
        end
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_full = full;
        req_start = IW'(st); req_len = (IW+1)'(len);
        while (!req_ready) @(negedge clk);
        acc_q.push_back(cyc + 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_all();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: compare at each completion pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            int a;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                chk(cyc - a == e.lat, {"R8 latency ", e.tag}, cyc - a, e.lat);
                for (int c = 0; c < C; c++) begin
                    chk(int'(best_prio[c*PW +: PW]) == e.prio[c], {"R2 prio ", e.tag},
                        int'(best_prio[c*PW +: PW]), e.prio[c]);
                    if (e.prio[c] != 255) begin
                        chk(int'(best_id[c*IW +: IW]) == e.id[c], {"R3 id ", e.tag},
                            int'(best_id[c*IW +: IW]), e.id[c]);
                        chk(int'(best_grp[c*GW +: GW]) == e.grp[c], {"R7 grp ", e.tag},
                            int'(best_grp[c*GW +: GW]), e.grp[c]);
                    end
                end
            end
        end
    end

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            begin : wd
                repeat (20000) @(posedge clk);
                wd_hit = 1'b1;
            end
            begin
                req_valid = 0; req_full = 0; req_start = '0; req_len = '0;
                for (int i = 0; i < N; i++) begin
                    s_elig[i] = 0; s_prio[i] = 8'h80; s_grp[i] = 2'(i);
                    s_tgt[i] = i[0]; s_tgtv[i] = 1;
                end
                for (int c = 0; c < C; c++)
                    for (int i = 0; i < 32; i++) begin
                        p_elig[c][i] = 0; p_prio[c][i] = 8'h80; p_grp[c][i] = 2'(i + 1);
                    end
                for (int c = 0; c < C; c++) begin m_prio[c] = 255; m_id[c] = 0; m_grp[c] = 0; end
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                for (int c = 0; c < C; c++)
                    chk(best_prio[c*PW +: PW] == 8'hFF, "R1 reset prio", int'(best_prio[c*PW +: PW]), 255);
                chk(!busy && req_ready && !done, "R1 reset flags", {busy, req_ready, done}, 2);

                // R3 R2 full recompute with a tie resolved by lower ID
                s_elig[40] = 1; s_prio[40] = 8'h30;
                s_elig[41] = 1; s_prio[41] = 8'h20;
                s_elig[60] = 1; s_prio[60] = 8'h30;
                p_elig[1][5] = 1; p_prio[1][5] = 8'h50;
                send(1, 0, 0, "full basic");
                wait_all();

                // R4 untargeted urgent ID is skipped
                s_elig[70] = 1; s_prio[70] = 8'h05; s_tgtv[70] = 0;
                send(1, 0, 0, "untargeted");
                wait_all();
                chk(best_id[0 +: IW] != IW'(70), "R4 skip", int'(best_id[0 +: IW]), 40);

                // R3 private wins equal-priority tie
                p_elig[0][3] = 1; p_prio[0][3] = 8'h30;
                send(1, 0, 0, "private tie");
                wait_all();

                // R5 R10 window starting mid-word finds better candidate
                s_elig[45] = 1; s_prio[45] = 8'h10;
                send(0, 44, 4, "range better");
                wait_all();

                // R6 old winner withdrawn inside window -> fallback
                s_elig[45] = 0;
                send(0, 45, 1, "fallback");
                wait_all();

                // R2 equal candidate re-accepted, equal higher ID ignored
                s_elig[43] = 1; s_prio[43] = 8'h20;
                send(0, 41, 3, "equal reaccept");
                wait_all();
                chk(best_id[IW +: IW] == IW'(41), "R2 equal higher id", int'(best_id[IW +: IW]), 41);

                // R9 second request held off while busy
                s_elig[90] = 1; s_prio[90] = 8'h01;
                send(0, 32, 64, "busy first");
                chk(busy && !req_ready, "R9 ready low when busy", int'(req_ready), 0);
                send(1, 0, 0, "busy second");
                wait_all();

                // R11 idle hold, then R3 empty
                repeat (5) @(negedge clk);
                chk(best_id[0 +: IW] == IW'(90), "R11 idle hold", int'(best_id[0 +: IW]), 90);
                for (int i = 0; i < N; i++) s_elig[i] = 0;
                for (int c = 0; c < C; c++) for (int i = 0; i < 32; i++) p_elig[c][i] = 0;
                send(1, 0, 0, "empty");
                wait_all();
                repeat (3) @(negedge clk);
                chk(!done, "R8 no stray done", int'(done), 0);
                disable wd;
            end
        join_any
        disable fork;
        if (wd_hit) chk(1'b0, "watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule